// File: doc/BRIEF.md
# Serial PHY Management Access Register

This block gives software one 32-bit register through which it reads and writes the 16-bit management registers of an external PHY. Writing the register starts a clause 22 management transaction on the MDC/MDIO pins. The register holds a 5-bit PHY register number, a 16-bit data field and a completion flag. The PHY address is a fixed parameter.

The completion flag works in opposite directions for the two operations. To write, software sets the flag together with the address and data, and the block clears the flag once the last data bit has left the pin. To read, software writes the flag as zero, and the block sets it once the 16 bits returned by the PHY are in the data field. Software polls the flag at a slow rate. A transaction lasts 64 MDC periods, which is well inside the window that polling allows.

MDC is the system clock divided by a parameter, and it stays low while the block is idle. MDIO has separate output, output-enable and input pins, so the tristate buffer sits outside the block.

Top module: `mdio_access_reg`

## Requirements
- R1: After reset the register reads zero, MDC is low and the MDIO output enable is low.
- R2: A host write with bit 31 = 1 sends one frame, most significant bit first. The frame is 32 ones, then 01, then opcode 01, then the PHY address, then wdata[20:16], then turnaround 10, then wdata[15:0]. The output enable stays high for all 64 bits.
- R3: A host write with bit 31 = 0 sends the same frame with opcode 10. The output enable drops for bit 46 (the start of the turnaround) and stays low through bit 63.
- R4: During a read, mdio_in is sampled on each rising MDC edge of bits 48 to 63, most significant bit first. When the frame ends, those 16 bits appear in bits 15:0 and bit 31 reads 1.
- R5: When a write frame ends, bit 31 reads 0 and bits 20:0 keep the values software wrote.
- R6: MDC is low for HALF_DIV clocks and then high for HALF_DIV clocks. Each frame bit lasts one MDC period. The block returns to idle exactly 128*HALF_DIV clocks after the accepted write, and MDC and the output enable are low while idle.
- R7: A host write that arrives while a frame is in progress is ignored. The register contents, the frame on the pins and the PHY register it targets do not change.
- R8: Bits 30:21 always read 0, whatever software wrote into them.
- R9: The PHY address field of every frame equals the PHY_ADDR parameter (default 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | One-cycle host write strobe |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Current register value |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO input data |

## Verification
A corrupted bit counter or shift register appears on mdio_out within one MDC period, and the bench compares that pin on every clock. A wrong divider count shifts the edges of MDC in the first bit of the frame. Losing the read or write direction shows up either as a wrong opcode at bit 34, as the output enable releasing at bit 46 when it should not (or failing to), or as a flag with the wrong polarity at the final edge. A lapse in ignoring writes during a frame changes host_rdata in the very next cycle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int TA_BIT     = 46;
    localparam int DATA_BIT   = 48;
    localparam int LAST_BIT   = FRAME_BITS - 1;

    typedef struct packed {
        logic                  busy;
        logic                  is_rd;
        logic [5:0]            bit_cnt;
        logic [FRAME_BITS-1:0] shreg;
        logic [15:0]           rdsh;
    } shift_state_t;

    typedef struct packed {
        logic        flag;
        logic [4:0]  addr;
        logic [15:0] data;
    } host_reg_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic tick_rise,
    output logic tick_fall
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_state_t;

    div_state_t d, q;
    logic       wrap;

    generate
        if (HALF_DIV == 1) begin : g_nodiv
            assign wrap = 1'b1;
        end else begin : g_div
            assign wrap = (q.cnt == CW'(HALF_DIV - 1));
        end
    endgenerate

    always_comb begin
        d = q;
        if (!en) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (wrap) begin
            d.cnt = '0;
            d.mdc = ~q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc       = q.mdc;
    assign tick_rise = en && wrap && !q.mdc;
    assign tick_fall = en && wrap &&  q.mdc;
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        is_read,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    input  logic        tick_rise,
    input  logic        tick_fall,
    input  logic        mdio_in,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdio_out,
    output logic        mdio_oe
);
    shift_state_t d, q;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (start && !q.busy) begin
            d.busy    = 1'b1;
            d.is_rd   = is_read;
            d.bit_cnt = '0;
            d.rdsh    = '0;
            d.shreg   = {32'hFFFF_FFFF, 2'b01, (is_read ? 2'b10 : 2'b01),
                         PHY_ADDR, reg_addr, 2'b10, wr_data};
        end else if (q.busy) begin
            if (tick_rise && q.is_rd && q.bit_cnt >= 6'(DATA_BIT))
                d.rdsh = {q.rdsh[14:0], mdio_in};
            if (tick_fall) begin
                d.shreg = {q.shreg[FRAME_BITS-2:0], 1'b0};
                if (q.bit_cnt == 6'(LAST_BIT)) begin
                    d.busy = 1'b0;
                    done   = 1'b1;
                end else begin
                    d.bit_cnt = q.bit_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign rd_data  = q.rdsh;
    assign mdio_out = q.shreg[FRAME_BITS-1];
    assign mdio_oe  = q.busy && !(q.is_rd && q.bit_cnt >= 6'(TA_BIT));
endmodule

// File: rtl/mdio_access_reg.sv
module mdio_access_reg
    import mdio_pkg::*;
#(
    parameter int         HALF_DIV = 2,
    parameter logic [4:0] PHY_ADDR = 5'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr_en,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    host_reg_t   d, q;
    logic        busy, done, start, tick_rise, tick_fall;
    logic [15:0] rd_data;
    logic        unused_wbits;

    assign unused_wbits = ^host_wdata[30:21];
    assign start        = host_wr_en && !busy;

    mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .en(busy),
        .mdc(mdc), .tick_rise(tick_rise), .tick_fall(tick_fall)
    );

    mdio_frame_shifter #(.PHY_ADDR(PHY_ADDR)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start),
        .is_read(!host_wdata[31]), .reg_addr(host_wdata[20:16]),
        .wr_data(host_wdata[15:0]), .tick_rise(tick_rise),
        .tick_fall(tick_fall), .mdio_in(mdio_in), .busy(busy),
        .done(done), .rd_data(rd_data), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe)
    );

    always_comb begin
        d = q;
        if (start) begin
            d.flag = host_wdata[31];
            d.addr = host_wdata[20:16];
            d.data = host_wdata[15:0];
        end else if (done) begin
            if (q.flag) begin
                d.flag = 1'b0;
            end else begin
                d.flag = 1'b1;
                d.data = rd_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign host_rdata = {q.flag, 10'b0, q.addr, q.data};
endmodule

// File: rtl/mdio_access_reg_chk.sv
module mdio_access_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        host_wr_en,
    input logic [31:0] host_rdata,
    input logic        mdc,
    input logic        mdio_oe
);
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr_en) |=> (!busy || $stable(host_rdata)));

    assert_write_clears_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(host_rdata[31])) |-> !host_rdata[31]);

    assert_read_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(host_rdata[31])) |-> host_rdata[31]);
endmodule

bind mdio_access_reg mdio_access_reg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .host_wr_en(host_wr_en),
    .host_rdata(host_rdata), .mdc(mdc), .mdio_oe(mdio_oe)
);

// File: tb/mdio_access_reg_tb.sv
`timescale 1ns/1ps
module mdio_access_reg_tb;
    localparam int H      = 2;
    localparam int FRAMEC = 128 * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    mdio_access_reg #(.HALF_DIV(H), .PHY_ADDR(5'd1)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always #4 clk = ~clk;

    // behavioural reference
    logic [15:0] phy [32];
    bit          m_busy = 0;
    bit          m_rd = 0;
    bit          m_flag = 0;
    logic [4:0]  m_addr = '0;
    logic [15:0] m_data = '0;
    int          m_cyc = 0;
    logic [63:0] m_frame = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_reg();
        return {m_flag, 10'b0, m_addr, m_data};
    endfunction

    task automatic model_step();
        if (m_busy) begin
            m_cyc++;
            if (m_cyc == FRAMEC) begin
                m_busy = 0;
                if (m_flag) m_flag = 0;
                else begin m_flag = 1; m_data = phy[m_addr]; end
            end
        end else if (host_wr_en) begin
            m_busy  = 1;
            m_cyc   = 0;
            m_flag  = host_wdata[31];
            m_rd    = !host_wdata[31];
            m_addr  = host_wdata[20:16];
            m_data  = host_wdata[15:0];
            m_frame = {32'hFFFF_FFFF, 2'b01, (m_rd ? 2'b10 : 2'b01), 5'd1, m_addr, 2'b10, m_data};
            if (!m_rd) phy[m_addr] = m_data;
        end
    endtask

    task automatic compare();
        int bitn;
        chk(host_rdata == m_reg(), "R4 R5 R8 register", host_rdata, m_reg());
        if (m_busy) begin
            bitn = m_cyc / (2 * H);
            chk(mdc == ((m_cyc / H) % 2 == 1), "R6 mdc", 32'(mdc), 32'((m_cyc / H) % 2));
            chk(mdio_oe == !(m_rd && bitn >= 46), "R3 oe", 32'(mdio_oe), 32'(!(m_rd && bitn >= 46)));
            if (mdio_oe)
                chk(mdio_out == m_frame[63 - bitn], "R2 R9 frame bit", 32'(mdio_out), 32'(m_frame[63 - bitn]));
            if (m_rd && bitn >= 48) mdio_in = phy[m_addr][63 - bitn];
            else if (m_rd && bitn == 47) mdio_in = 1'b0;
            else mdio_in = 1'b1;
        end else begin
            chk(!mdc && !mdio_oe, "R6 idle pins", {mdc, mdio_oe}, 32'd0);
            mdio_in = 1'b1;
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        model_step();
        compare();
    endtask

    task automatic cmd(input logic [31:0] w);
        host_wdata = w;
        host_wr_en = 1'b1;
        cycle();
        host_wr_en = 1'b0;
        while (m_busy) cycle();
        cycle();
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) phy[i] = 16'(i * 16'h1111) ^ 16'h5A5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(host_rdata == 32'd0, "R1 reset rdata", host_rdata, 32'd0);
        chk(!mdc && !mdio_oe, "R1 reset pins", {mdc, mdio_oe}, 32'd0);

        cmd(32'h8005_A5C3);                         // R2 write
        chk(host_rdata == 32'h0005_A5C3, "R5 write flag cleared", host_rdata, 32'h0005_A5C3);
        cmd(32'h0005_0000);                         // R3 R4 read back
        chk(host_rdata == 32'h8005_A5C3, "R4 read data", host_rdata, 32'h8005_A5C3);
        cmd(32'hFFFF_0001);                         // R8 reserved bits written
        chk(host_rdata == 32'h001F_0001, "R8 reserved zero", host_rdata, 32'h001F_0001);
        cmd(32'h0000_0000);
        chk(host_rdata == {16'h8000, phy[0]}, "R4 read reg 0", host_rdata, {16'h8000, phy[0]});
        cmd(32'h8003_FFFF);
        cmd(32'h0003_1234);
        chk(host_rdata == 32'h8003_FFFF, "R4 read all ones", host_rdata, 32'h8003_FFFF);

        // R7: write during a read is ignored
        host_wdata = 32'h000A_0000;
        host_wr_en = 1'b1;
        cycle();
        host_wr_en = 1'b0;
        repeat (40) cycle();
        host_wdata = 32'h800C_BEEF;
        host_wr_en = 1'b1;
        cycle();
        host_wr_en = 1'b0;
        chk(host_rdata == 32'h000A_0000, "R7 busy write ignored", host_rdata, 32'h000A_0000);
        while (m_busy) cycle();
        cycle();
        chk(host_rdata == {16'h800A, phy[10]}, "R7 read unaffected", host_rdata, {16'h800A, phy[10]});
        cmd(32'h000C_0000);
        chk(host_rdata[15:0] == (16'(12 * 16'h1111) ^ 16'h5A5A), "R7 phy reg untouched",
            host_rdata, {16'h800C, 16'(12 * 16'h1111) ^ 16'h5A5A});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        done_flag = 1;
        $finish;
    end
endmodule